// File: doc/BRIEF.md
# Uplink Symbol Mapper and Frame Sequencer

This block turns one redundancy version of 1380 coded bits into a timed stream of uplink samples. Incoming bits are packed three at a time into symbols. Each symbol selects one copy of a shared basic waveform. Two of its bits choose a cyclic position, and the third chooses the sign. The waveform is held in a small table that is fixed by parameters, with one table for each modulator mode.

A start pulse launches one pass through a fixed schedule of speech frames. Each speech frame is 160 samples long. The schedule interleaves muting gaps, three data segments and synchronization-fragment slots. The segment lengths depend on the modulator mode, which is latched at start. The fast mode uses a 16-sample modulation frame and the robust mode uses a 32-sample one.

Each pulse on the sample strobe yields one signed 16-bit sample, together with a one-hot slot-type indication. Sync slots output zero and raise their own flag, so that an external fragment source can fill them. Data bits arrive on a valid/ready stream, and the block pulls exactly the 1380 bits that the schedule needs.

Top module: `uplink_slot_sequencer`

## Requirements
- R1: After reset, samp_vld, done, bit_ready and all slot flags are 0.
- R2: While a pass is running, every cycle with smp_stb high produces exactly one output sample, with samp_vld high in the following cycle. smp_stb has no effect while idle.
- R3: In fast mode (robust_sel=0 at start), the pass consists of these speech frames in order: mute 1, data 15, sync 4, mute 2, data 15, sync 4, mute 2, data 16, sync 4, mute 3. That is 10560 samples in total.
- R4: In robust mode (robust_sel=1 at start), the pass consists of: mute 1, data 30, sync 4, mute 4, data 30, sync 4, mute 4, data 32, sync 4, mute 3. That is 18560 samples in total.
- R5: Mute samples and sync samples are 0. Each has its own flag (slot_mute or slot_sync). Exactly one of slot_mute, slot_data and slot_sync is high when samp_vld is high, and none is high otherwise.
- R6: Each symbol takes three consecutive stream bits, with the first received bit as the symbol's bit 2. A new symbol starts at sample 0 of every modulation frame inside a data segment.
- R7: Symbols 0..3 have sign +1 and shift s·L/4. Symbols 4..7 have sign −1 and shift (7−s)·L/4. L is 16 in fast mode and 32 in robust mode.
- R8: A data sample at position n (0..L−1) in its modulation frame equals sign × W[(n − k) mod L]. W is the waveform table for the mode and k is the symbol's shift.
- R9: Negating a table value of −32768 yields +32767.
- R10: bit_ready is only high during a pass. Exactly 1380 bits are accepted per pass in either mode.
- R11: done pulses for one cycle together with the last sample of the final mute segment. The block then goes idle and emits no further samples.
- R12: A start pulse during a pass is ignored.
- R13: robust_sel is sampled only at start. Changes during a pass have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a pass when idle |
| robust_sel | input | 1 | Mode select: 0 fast, 1 robust (latched at start) |
| smp_stb | input | 1 | One pulse per output sample |
| bit_in | input | 1 | Coded data bit |
| bit_valid | input | 1 | bit_in is valid |
| bit_ready | output | 1 | Block accepts bit_in this cycle |
| samp_out | output | 16 | Signed output sample |
| samp_vld | output | 1 | samp_out and slot flags valid |
| slot_mute | output | 1 | Sample belongs to a muting gap |
| slot_data | output | 1 | Sample belongs to a data segment |
| slot_sync | output | 1 | Sample is a sync-fragment slot |
| done | output | 1 | Last sample of the pass |

## Verification
A wrong segment or frame counter shows up as a shift in the slot flags at the next segment boundary, at most one speech frame later. It also changes the total sample count and moves the done pulse. A wrong symbol-hold or bit-packing state corrupts the first data sample of the affected modulation frame, so the bench compares every sample against a model built from the stream bits. A wrong shift or sign shows on the same sample. A faulty bit budget shows in the handshake count at the end of the pass and in bit_ready after done.

// File: rtl/ulseq_pkg.sv
// Shared types and schedule tables for the uplink slot sequencer.
// Assumes a ten-segment schedule: mute, then three (data, sync, mute) groups.
package ulseq_pkg;

    localparam int SAMP_W   = 16;
    localparam int NUM_SEGS = 10;
    localparam logic [3:0] LAST_SEG = 4'(NUM_SEGS - 1);
    localparam logic signed [SAMP_W-1:0] SAMP_MIN = 16'sh8000;
    localparam logic signed [SAMP_W-1:0] SAMP_MAX = 16'sh7fff;

    typedef enum logic [1:0] {
        SLOT_MUTE = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_SYNC = 2'd2
    } slot_e;

    // Kind of slot held by a schedule segment
    function automatic slot_e seg_kind(input logic [3:0] idx);
        case (idx)
            4'd1, 4'd4, 4'd7: return SLOT_DATA;
            4'd2, 4'd5, 4'd8: return SLOT_SYNC;
            default:          return SLOT_MUTE;
        endcase
    endfunction

    // Length of a schedule segment in speech frames for the given mode
    function automatic logic [5:0] seg_frames(input logic [3:0] idx, input logic robust);
        case (idx)
            4'd0:       return 6'd1;
            4'd1, 4'd4: return robust ? 6'd30 : 6'd15;
            4'd3, 4'd6: return robust ? 6'd4  : 6'd2;
            4'd7:       return robust ? 6'd32 : 6'd16;
            4'd9:       return 6'd3;
            default:    return 6'd4;
        endcase
    endfunction

    // Default pulse shape: peak at index 0, falling linearly toward the middle
    function automatic int shape(input int i, input int len);
        int d;
        d = (i < len / 2) ? i : len - i;
        return 20000 - d * (36000 / len);
    endfunction

    function automatic logic [16*SAMP_W-1:0] default_fast_wave();
        logic [16*SAMP_W-1:0] v;
        v = '0;
        for (int i = 0; i < 16; i++) v[i*SAMP_W +: SAMP_W] = 16'(shape(i, 16));
        return v;
    endfunction

    function automatic logic [32*SAMP_W-1:0] default_robust_wave();
        logic [32*SAMP_W-1:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) v[i*SAMP_W +: SAMP_W] = 16'(shape(i, 32));
        return v;
    endfunction

endpackage

// File: rtl/ulseq_sched.sv
// Schedule walker: tracks segment, speech frame, sample and modulation-frame
// position. Advances once per sample strobe while a pass runs.
// Assumes FRAME_SAMPLES is a multiple of both modulation frame lengths.
module ulseq_sched
    import ulseq_pkg::*;
#(
    parameter int FRAME_SAMPLES = 160,
    parameter int FAST_LEN      = 16,
    parameter int ROBUST_LEN    = 32,
    parameter int MOD_W         = $clog2(ROBUST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stb,
    input  logic             robust_sel,
    output logic             run,
    output logic             robust,
    output slot_e            kind,
    output logic [MOD_W-1:0] mod_n,
    output logic             sym_start,
    output logic             last_sample
);
    localparam int SMP_W = $clog2(FRAME_SAMPLES);

    logic [3:0]       seg;
    logic [5:0]       frm;
    logic [SMP_W-1:0] smp;
    logic [5:0]       frames_now;
    logic             smp_last, frm_last, seg_last, mod_last;

    // Decode end-of-count conditions for the current position
    always_comb begin
        frames_now  = seg_frames(seg, robust);
        kind        = seg_kind(seg);
        smp_last    = (smp == SMP_W'(FRAME_SAMPLES - 1));
        frm_last    = (frm == frames_now - 6'd1);
        seg_last    = (seg == LAST_SEG);
        mod_last    = robust ? (mod_n == MOD_W'(ROBUST_LEN - 1))
                             : (mod_n == MOD_W'(FAST_LEN - 1));
        sym_start   = run && (kind == SLOT_DATA) && (mod_n == '0);
        last_sample = run && seg_last && frm_last && smp_last;
    end

    // Start a pass from idle, otherwise step the position on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            robust <= 1'b0;
            seg    <= '0;
            frm    <= '0;
            smp    <= '0;
            mod_n  <= '0;
        end else if (!run) begin
            if (start) begin
                run    <= 1'b1;
                robust <= robust_sel;
                seg    <= '0;
                frm    <= '0;
                smp    <= '0;
                mod_n  <= '0;
            end
        end else if (stb) begin
            mod_n <= (mod_last || smp_last) ? '0 : mod_n + 1'b1;
            if (smp_last) begin
                smp <= '0;
                if (frm_last) begin
                    frm <= '0;
                    if (seg_last) run <= 1'b0;
                    else          seg <= seg + 4'd1;
                end else begin
                    frm <= frm + 6'd1;
                end
            end else begin
                smp <= smp + 1'b1;
            end
        end
    end

    AST_SEG_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (seg <= LAST_SEG) && (frm < frames_now)); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(stb && last_sample)) |=> run && $stable(robust)); // R12

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $changed(robust_sel)) |=> $stable(robust)); // R13

endmodule

// File: rtl/ulseq_bitpack.sv
// Bit packer: collects stream bits MSB-first into a symbol register and
// hands a full symbol over when a data modulation frame begins.
// Assumes the stream stays ahead of the schedule (a full symbol on each take).
module ulseq_bitpack #(
    parameter int BITS_PER_SYM = 3,
    parameter int TOTAL_BITS   = 1380
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    run,
    input  logic                    bit_in,
    input  logic                    bit_valid,
    input  logic                    take,
    output logic                    bit_ready,
    output logic [BITS_PER_SYM-1:0] sym
);
    localparam int CNT_W = $clog2(BITS_PER_SYM + 1);
    localparam int TOT_W = $clog2(TOTAL_BITS + 1);

    logic [BITS_PER_SYM-1:0] acc;
    logic [CNT_W-1:0]        acc_cnt;
    logic [TOT_W-1:0]        taken;
    logic                    fire;

    // Accept while running, with room in the packer and budget left
    always_comb begin
        bit_ready = run && (acc_cnt < CNT_W'(BITS_PER_SYM)) && (taken < TOT_W'(TOTAL_BITS));
        fire      = bit_ready && bit_valid;
        sym       = acc;
    end

    // Shift in accepted bits; empty the packer when the symbol is taken
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc     <= '0;
            acc_cnt <= '0;
            taken   <= '0;
        end else if (take) begin
            acc_cnt <= '0;
        end else if (fire) begin
            acc     <= {acc[BITS_PER_SYM-2:0], bit_in};
            acc_cnt <= acc_cnt + 1'b1;
            taken   <= taken + 1'b1;
        end
    end

    AST_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (acc_cnt == CNT_W'(BITS_PER_SYM))); // R6

    AST_BIT_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        taken <= TOT_W'(TOTAL_BITS)); // R10

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !bit_ready); // R10

endmodule

// File: rtl/ulseq_shaper.sv
// Waveform shaper: maps the current symbol to sign and cyclic shift, reads
// the mode's waveform table at (n - k) mod L and registers the sample.
// Assumes both modulation frame lengths are powers of two.
module ulseq_shaper
    import ulseq_pkg::*;
#(
    parameter int FAST_LEN   = 16,
    parameter int ROBUST_LEN = 32,
    parameter int MOD_W      = $clog2(ROBUST_LEN),
    parameter logic [FAST_LEN*SAMP_W-1:0]   WAVE_FAST   = default_fast_wave(),
    parameter logic [ROBUST_LEN*SAMP_W-1:0] WAVE_ROBUST = default_robust_wave()
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  slot_e                    kind,
    input  logic                     robust,
    input  logic [2:0]               sym_new,
    input  logic                     sym_start,
    input  logic [MOD_W-1:0]         mod_n,
    output logic signed [SAMP_W-1:0] samp,
    output logic                     samp_vld,
    output logic                     f_mute,
    output logic                     f_data,
    output logic                     f_sync
);
    localparam int FAST_W = $clog2(FAST_LEN);

    logic signed [SAMP_W-1:0] rom_f [FAST_LEN];
    logic signed [SAMP_W-1:0] rom_r [ROBUST_LEN];

    genvar g;
    for (g = 0; g < FAST_LEN; g++) begin : g_fast_rom
        assign rom_f[g] = WAVE_FAST[g*SAMP_W +: SAMP_W];
    end
    for (g = 0; g < ROBUST_LEN; g++) begin : g_robust_rom
        assign rom_r[g] = WAVE_ROBUST[g*SAMP_W +: SAMP_W];
    end

    logic [2:0]               sym_hold, cur_sym;
    logic                     neg;
    logic [1:0]               pos;
    logic [MOD_W-1:0]         shift, rd;
    logic signed [SAMP_W-1:0] w, val;

    // Symbol to sign/shift mapping and signed table lookup
    always_comb begin
        cur_sym = sym_start ? sym_new : sym_hold;
        neg     = cur_sym[2];
        pos     = neg ? ~cur_sym[1:0] : cur_sym[1:0];
        shift   = robust ? MOD_W'(pos) * MOD_W'(ROBUST_LEN / 4)
                         : MOD_W'(pos) * MOD_W'(FAST_LEN / 4);
        rd      = mod_n - shift;
        w       = robust ? rom_r[rd] : rom_f[rd[FAST_W-1:0]];
        val     = !neg ? w : ((w == SAMP_MIN) ? SAMP_MAX : -w);
    end

    // Hold the symbol for its frame and register one sample per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_hold <= '0;
            samp     <= '0;
            samp_vld <= 1'b0;
            f_mute   <= 1'b0;
            f_data   <= 1'b0;
            f_sync   <= 1'b0;
        end else begin
            samp_vld <= fire;
            if (fire && sym_start) sym_hold <= sym_new;
            if (fire) begin
                samp   <= (kind == SLOT_DATA) ? val : '0;
                f_mute <= (kind == SLOT_MUTE);
                f_data <= (kind == SLOT_DATA);
                f_sync <= (kind == SLOT_SYNC);
            end else begin
                samp   <= '0;
                f_mute <= 1'b0;
                f_data <= 1'b0;
                f_sync <= 1'b0;
            end
        end
    end

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |-> $onehot({f_mute, f_data, f_sync})); // R5

    AST_SILENT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |-> (samp == '0) && !f_mute && !f_data && !f_sync); // R2

endmodule

// File: rtl/uplink_slot_sequencer.sv
// Top level: joins schedule walker, bit packer and waveform shaper, and
// raises done with the last sample of a pass.
// Assumes at least BITS_PER_SYM+1 clocks between sample strobes.
module uplink_slot_sequencer
    import ulseq_pkg::*;
#(
    parameter int FRAME_SAMPLES = 160,
    parameter int FAST_LEN      = 16,
    parameter int ROBUST_LEN    = 32,
    parameter int BITS_PER_SYM  = 3,
    parameter int TOTAL_BITS    = 1380,
    parameter logic [FAST_LEN*SAMP_W-1:0]   WAVE_FAST   = default_fast_wave(),
    parameter logic [ROBUST_LEN*SAMP_W-1:0] WAVE_ROBUST = default_robust_wave()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              robust_sel,
    input  logic              smp_stb,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic              bit_ready,
    output logic signed [15:0] samp_out,
    output logic              samp_vld,
    output logic              slot_mute,
    output logic              slot_data,
    output logic              slot_sync,
    output logic              done
);
    localparam int MOD_W = $clog2(ROBUST_LEN);

    logic             run, robust, sym_start, last_sample, fire, take, clear;
    slot_e            kind;
    logic [MOD_W-1:0] mod_n;
    logic [BITS_PER_SYM-1:0] sym;

    // Glue: strobe qualification, symbol hand-over and pass launch
    always_comb begin
        fire  = run && smp_stb;
        take  = fire && sym_start;
        clear = !run && start;
    end

    ulseq_sched #(
        .FRAME_SAMPLES(FRAME_SAMPLES),
        .FAST_LEN     (FAST_LEN),
        .ROBUST_LEN   (ROBUST_LEN),
        .MOD_W        (MOD_W)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stb        (smp_stb),
        .robust_sel (robust_sel),
        .run        (run),
        .robust     (robust),
        .kind       (kind),
        .mod_n      (mod_n),
        .sym_start  (sym_start),
        .last_sample(last_sample)
    );

    ulseq_bitpack #(
        .BITS_PER_SYM(BITS_PER_SYM),
        .TOTAL_BITS  (TOTAL_BITS)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .run      (run),
        .bit_in   (bit_in),
        .bit_valid(bit_valid),
        .take     (take),
        .bit_ready(bit_ready),
        .sym      (sym)
    );

    ulseq_shaper #(
        .FAST_LEN   (FAST_LEN),
        .ROBUST_LEN (ROBUST_LEN),
        .MOD_W      (MOD_W),
        .WAVE_FAST  (WAVE_FAST),
        .WAVE_ROBUST(WAVE_ROBUST)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .kind     (kind),
        .robust   (robust),
        .sym_new  (sym[2:0]),
        .sym_start(sym_start),
        .mod_n    (mod_n),
        .samp     (samp_out),
        .samp_vld (samp_vld),
        .f_mute   (slot_mute),
        .f_data   (slot_data),
        .f_sync   (slot_sync)
    );

    // Pulse done together with the final sample of the pass
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fire && last_sample;
    end

    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> samp_vld && slot_mute); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run); // R11

endmodule

// File: tb/tb_uplink_slot_sequencer.sv
module tb_uplink_slot_sequencer;

    localparam int NBITS = 1380;

    function automatic int wf(input bit rob, input int i);
        if (i == 5) return -32768;
        return rob ? (i * 900 - 14000) : (i * 2000 - 15000);
    endfunction

    function automatic logic [255:0] mk_fast();
        logic [255:0] v;
        v = '0;
        for (int i = 0; i < 16; i++) v[i*16 +: 16] = 16'(wf(1'b0, i));
        return v;
    endfunction

    function automatic logic [511:0] mk_rob();
        logic [511:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) v[i*16 +: 16] = 16'(wf(1'b1, i));
        return v;
    endfunction

    localparam logic [255:0] TB_WF = mk_fast();
    localparam logic [511:0] TB_WR = mk_rob();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, robust_sel = 1'b0, smp_stb = 1'b0, bit_in = 1'b0, bit_valid = 1'b0;
    logic bit_ready, samp_vld, slot_mute, slot_data, slot_sync, done;
    logic signed [15:0] samp_out;

    always #4 clk = ~clk;

    uplink_slot_sequencer #(.WAVE_FAST(TB_WF), .WAVE_ROBUST(TB_WR)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .robust_sel(robust_sel),
        .smp_stb(smp_stb), .bit_in(bit_in), .bit_valid(bit_valid),
        .bit_ready(bit_ready), .samp_out(samp_out), .samp_vld(samp_vld),
        .slot_mute(slot_mute), .slot_data(slot_data), .slot_sync(slot_sync),
        .done(done)
    );

    int checks = 0, errors = 0;
    bit tb_bits [NBITS];
    int exp_s[$], exp_k[$], exp_d[$], exp_sat[$];
    int n_samples = 0, hs = 0, bit_idx = 0;
    bit feed_on = 0, stb_en = 0, seen_done = 0, finished = 0;

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Driver side: build the bit stream and the expected sample queue
    task automatic build_expect(input bit rob, input int seed);
        int lens[10];
        int kinds[10];
        int lfsr, bi, sym, L, n, k, w, v;
        bit is_last;
        lfsr = seed;
        for (int i = 0; i < NBITS; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hffff;
            tb_bits[i] = lfsr[0];
        end
        if (rob) lens = '{1, 30, 4, 4, 30, 4, 4, 32, 4, 3};
        else     lens = '{1, 15, 4, 2, 15, 4, 2, 16, 4, 3};
        kinds = '{0, 1, 2, 0, 1, 2, 0, 1, 2, 0};
        L = rob ? 32 : 16;
        bi = 0;
        sym = 0;
        for (int sg = 0; sg < 10; sg++)
            for (int f = 0; f < lens[sg]; f++)
                for (int s = 0; s < 160; s++) begin
                    n = s % L;
                    v = 0;
                    w = 1;
                    if (kinds[sg] == 1) begin
                        if (n == 0) begin
                            sym = tb_bits[bi] * 4 + tb_bits[bi+1] * 2 + tb_bits[bi+2];
                            bi += 3;
                        end
                        k = ((sym < 4) ? sym : 7 - sym) * (L / 4);
                        w = wf(rob, (n - k + L) % L);
                        if (sym < 4) v = w;
                        else v = (w == -32768) ? 32767 : -w;
                    end
                    is_last = (sg == 9) && (f == lens[sg] - 1) && (s == 159);
                    exp_s.push_back(v);
                    exp_k.push_back(kinds[sg]);
                    exp_d.push_back(int'(is_last));
                    exp_sat.push_back(int'(kinds[sg] == 1 && sym >= 4 && w == -32768));
                end
    endtask

    // Monitor and strobe driver: compare first, then drive the next strobe
    initial begin : monitor
        int cnt;
        bit prev_stb;
        int gk, es, ek, ed, esat;
        string tag;
        cnt = 0;
        prev_stb = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stb && exp_s.size() > 0)
                    chk(samp_vld == 1'b1, "R2 sample after strobe", int'(samp_vld), 1);
                if (samp_vld) begin
                    n_samples++;
                    gk = slot_mute ? 0 : slot_data ? 1 : slot_sync ? 2 : 3;
                    if ({slot_mute, slot_data, slot_sync} != 3'b001 &&
                        {slot_mute, slot_data, slot_sync} != 3'b010 &&
                        {slot_mute, slot_data, slot_sync} != 3'b100) gk = 3;
                    if (exp_s.size() == 0) begin
                        chk(1'b0, "R11 sample after done", int'(samp_out), 0);
                    end else begin
                        es = exp_s.pop_front();
                        ek = exp_k.pop_front();
                        ed = exp_d.pop_front();
                        esat = exp_sat.pop_front();
                        tag = (ek == 1) ? ((esat != 0) ? "R9 saturated sample" : "R6 R7 R8 data sample")
                                        : "R5 quiet slot sample";
                        chk(int'(samp_out) == es, tag, int'(samp_out), es);
                        chk(gk == ek, "R5 R3 R4 slot kind", gk, ek);
                        chk(int'(done) == ed, "R11 done timing", int'(done), ed);
                        if (done) seen_done = 1;
                    end
                end else if (done) begin
                    chk(1'b0, "R11 done without sample", 1, 0);
                end
            end
            if (stb_en) begin
                smp_stb = (cnt == 0);
                cnt = (cnt + 1) % 4;
            end else begin
                smp_stb = 0;
                cnt = 0;
            end
            prev_stb = smp_stb;
        end
    end

    // Bit stream driver with valid/ready handshake
    initial begin : feeder
        bit fire_prev;
        fire_prev = 0;
        forever begin
            @(negedge clk);
            if (fire_prev) begin
                bit_idx++;
                hs++;
            end
            if (feed_on && bit_idx < NBITS) begin
                bit_valid = 1;
                bit_in = tb_bits[bit_idx];
            end else begin
                bit_valid = 0;
                bit_in = 0;
            end
            fire_prev = bit_valid && bit_ready;
        end
    end

    task automatic run_pass(input bit rob, input bit disturb_mode, input bit disturb_start, input int seed);
        int t;
        exp_s.delete(); exp_k.delete(); exp_d.delete(); exp_sat.delete();
        build_expect(rob, seed);
        n_samples = 0;
        hs = 0;
        bit_idx = 0;
        seen_done = 0;
        feed_on = 1;
        @(negedge clk);
        robust_sel = rob;
        start = 1;
        @(negedge clk);
        start = 0;
        stb_en = 1;
        t = 0;
        while (!(seen_done && exp_s.size() == 0) && t < 100000) begin
            @(negedge clk);
            t++;
            if (t == 1000 && disturb_mode) robust_sel = ~rob;   // R13
            if (t == 5000 && disturb_start) start = 1;          // R12
            if (t == 5001) start = 0;
        end
        chk(t < 100000, "R11 pass completes", t, 0);
        repeat (40) @(negedge clk);
        stb_en = 0;
        feed_on = 0;
        if (rob) chk(n_samples == 18560, "R4 R12 robust sample count", n_samples, 18560);
        else     chk(n_samples == 10560, "R3 R13 fast sample count", n_samples, 10560);
        chk(hs == NBITS, "R10 bits accepted", hs, NBITS);
        chk(bit_ready == 1'b0, "R10 ready low after done", int'(bit_ready), 0);
        chk(exp_s.size() == 0, "R11 all samples seen", exp_s.size(), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(samp_vld == 0, "R1 samp_vld after reset", int'(samp_vld), 0);
        chk(done == 0, "R1 done after reset", int'(done), 0);
        chk(bit_ready == 0, "R1 bit_ready after reset", int'(bit_ready), 0);
        chk({slot_mute, slot_data, slot_sync} == 3'b000, "R1 flags after reset",
            int'({slot_mute, slot_data, slot_sync}), 0);
        run_pass(1'b0, 1'b1, 1'b0, 16'hACE1);
        run_pass(1'b1, 1'b0, 1'b1, 16'h1D2B);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule